// File: doc/BRIEF.md
# Multi-Block Transfer Sequencer with Automatic Stop

This block runs the data phase of a block-oriented memory-card transfer. Software programs a block count and a transfer-mode word. When the mode word is written with its data-present bit set, a transfer starts. The sequencer counts the completed blocks that the data path reports. In a counted multi-block transfer with automatic stop enabled, it asks the command issuer to send the stop command (CMD12) once the final block has finished.

A single-block transfer always ends after one block. In that case the automatic-stop setting has no effect. A multi-block transfer with block counting switched off never ends by itself, and neither does one with automatic stop switched off. Both run until software raises the abort input. When DMA is enabled, a one-cycle DMA start strobe is sent at the moment the data phase begins.

The stop request is a request/acknowledge handshake toward the command issuer. `stop_req` rises and stays high until a cycle in which `stop_ack` is sampled high. `stop_ack` has no effect while `stop_req` is low. Completion is reported with a one-cycle `done` pulse. The block counter and the mode word are visible on `blocks_left` and `mode_rd`.

Top module: `blkxfer_seq`

## Requirements
- R1: The mode word uses these bits: bit0 DMA enable, bit1 block-count enable, bit2 automatic-stop enable, bit4 direction (0 = write host to card, 1 = read card to host), bit5 multi-block, bit6 data present. Bits 3 and 7 are not stored and always read as zero on `mode_rd`. `dir` follows the stored bit4.
- R2: A mode write with bit6 set, made while idle, starts a transfer. From the next cycle `busy` is high. `blocks_left` is loaded with the stored block count for a multi-block transfer, or with 1 for a single-block transfer.
- R3: `dma_start` pulses high for exactly one cycle, the cycle after a start that begins a data phase with bit0 set. It stays low otherwise.
- R4: In a counted transfer, each `block_done` pulse during the data phase lowers `blocks_left` by one.
- R5: In a counted multi-block transfer with automatic stop enabled, `stop_req` rises the cycle after the final block. It stays high until `stop_ack` is sampled.
- R6: `done` pulses for one cycle, the cycle after `stop_ack` is accepted, and `busy` falls at the same time. `done` never rises while a stop request is still waiting.
- R7: In a single-block transfer, the automatic-stop bit is ignored. One block ends the transfer with `done`, and `stop_req` never rises.
- R8: In a multi-block transfer with counting off, `block_done` leaves `blocks_left` unchanged, and the transfer stays busy without end.
- R9: In a counted multi-block transfer with automatic stop off, the transfer stays busy after the final block and ignores further blocks.
- R10: `abort` during a transfer returns the sequencer to idle on the next cycle, without a `done` pulse, and drops any pending `stop_req`.
- R11: A counted multi-block start with a stored count of zero completes at once. `done` pulses on the next cycle, while `busy`, `stop_req` and `dma_start` stay low.
- R12: Writes to the mode word or the block count are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 8 | Mode word to write |
| count_wr | input | 1 | Write strobe for the block count |
| count_wdata | input | CNT_W | Block count to write |
| block_done | input | 1 | One-cycle pulse from the data path per finished block |
| abort | input | 1 | Software abort of the running transfer |
| stop_req | output | 1 | Request to send the stop command |
| stop_ack | input | 1 | Command issuer has taken the stop request |
| dma_start | output | 1 | One-cycle DMA start strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-complete pulse |
| dir | output | 1 | Stored direction (1 = read) |
| mode_rd | output | 8 | Readback of the stored mode word |
| blocks_left | output | CNT_W | Current block counter value |

## Verification
The hardest state to reach from the ports is a stop request that is left waiting. The stimulus holds `stop_ack` low for several cycles after the final block, and checks that `stop_req` stays high and `done` stays low. A separate scenario aborts while the request is pending. Ignored register writes are also hard to see, because they change no output while busy. The stimulus therefore starts a second transfer after the first one ends, and shows through `blocks_left` that the count written during the busy period was dropped.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int MODE_W   = 8;
  localparam int MB_DMA   = 0;
  localparam int MB_CNTEN = 1;
  localparam int MB_ASTOP = 2;
  localparam int MB_DIR   = 4;
  localparam int MB_MULTI = 5;
  localparam int MB_DP    = 6;
  localparam logic [MODE_W-1:0] MODE_KEEP = (MODE_W'(1) << MB_DMA) | (MODE_W'(1) << MB_CNTEN) |
                                            (MODE_W'(1) << MB_ASTOP) | (MODE_W'(1) << MB_DIR) |
                                            (MODE_W'(1) << MB_MULTI) | (MODE_W'(1) << MB_DP);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STOP, ST_HALT} seq_state_e;
endpackage

// File: rtl/blkxfer_cfg.sv
module blkxfer_cfg
  import blkxfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              count_wr,
  input  logic [CNT_W-1:0]  count_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  count_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      count_q <= '0;
    end else if (!busy) begin
      if (mode_wr)  mode_q  <= mode_wdata & MODE_KEEP;
      if (count_wr) count_q <= count_wdata;
    end
  end

  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mode_q) && $stable(count_q)));
endmodule

// File: rtl/blkxfer_cnt.sv
module blkxfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             at_one
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (dec && cnt != '0)    cnt <= cnt - ONE;
  end

  assign at_one = (cnt == ONE);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));
  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !load) |=> $stable(cnt));
endmodule

// File: rtl/blkxfer_fsm.sv
module blkxfer_fsm
  import blkxfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic st_multi,
  input  logic st_cnten,
  input  logic st_dma,
  input  logic st_zero,
  input  logic cur_multi,
  input  logic cur_cnten,
  input  logic cur_astop,
  input  logic block_done,
  input  logic cnt_at_one,
  input  logic abort,
  input  logic stop_ack,
  output logic load,
  output logic dec,
  output logic stop_req,
  output logic busy,
  output logic done,
  output logic dma_start
);
  seq_state_e state_q, state_d;
  logic       done_ev, dma_ev, counted, last_blk, zero_case;

  assign counted   = cur_multi ? cur_cnten : 1'b1;
  assign zero_case = st_multi && st_cnten && st_zero;
  assign dec       = (state_q == ST_DATA) && block_done && counted && !abort;
  assign last_blk  = dec && cnt_at_one;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    done_ev = 1'b0;
    dma_ev  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (zero_case) begin
          done_ev = 1'b1;
        end else begin
          state_d = ST_DATA;
          load    = 1'b1;
          dma_ev  = st_dma;
        end
      end
      ST_DATA: begin
        if (abort)                      state_d = ST_IDLE;
        else if (last_blk) begin
          if (cur_multi && cur_astop)   state_d = ST_STOP;
          else if (cur_multi)           state_d = ST_HALT;
          else begin
            state_d = ST_IDLE;
            done_ev = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (abort)                      state_d = ST_IDLE;
        else if (stop_ack) begin
          state_d = ST_IDLE;
          done_ev = 1'b1;
        end
      end
      ST_HALT: if (abort)               state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done      <= 1'b0;
      dma_start <= 1'b0;
    end else begin
      state_q   <= state_d;
      done      <= done_ev;
      dma_start <= dma_ev;
    end
  end

  assign stop_req = (state_q == ST_STOP);
  assign busy     = (state_q != ST_IDLE);

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stop_ack && !abort) |=> stop_req);
  // R6
  done_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stop_ack) |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3
  dma_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> busy);
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (!busy && !done && !stop_req));
  // R9
  halt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !abort) |=> (state_q == ST_HALT));
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              count_wr,
  input  logic [CNT_W-1:0]  count_wdata,
  input  logic              block_done,
  input  logic              abort,
  output logic              stop_req,
  input  logic              stop_ack,
  output logic              dma_start,
  output logic              busy,
  output logic              done,
  output logic              dir,
  output logic [MODE_W-1:0] mode_rd,
  output logic [CNT_W-1:0]  blocks_left
);
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  count_q, load_val;
  logic              start, load, dec, at_one;

  assign start    = mode_wr && mode_wdata[MB_DP];
  assign load_val = mode_wdata[MB_MULTI] ? count_q : CNT_W'(1);
  assign mode_rd  = mode_q;
  assign dir      = mode_q[MB_DIR];

  blkxfer_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .count_wr(count_wr), .count_wdata(count_wdata),
    .mode_q(mode_q), .count_q(count_q)
  );

  blkxfer_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .dec(dec), .cnt(blocks_left), .at_one(at_one)
  );

  blkxfer_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .st_multi(mode_wdata[MB_MULTI]), .st_cnten(mode_wdata[MB_CNTEN]),
    .st_dma(mode_wdata[MB_DMA]), .st_zero(count_q == '0),
    .cur_multi(mode_q[MB_MULTI]), .cur_cnten(mode_q[MB_CNTEN]),
    .cur_astop(mode_q[MB_ASTOP]),
    .block_done(block_done), .cnt_at_one(at_one), .abort(abort),
    .stop_ack(stop_ack), .load(load), .dec(dec), .stop_req(stop_req),
    .busy(busy), .done(done), .dma_start(dma_start)
  );
endmodule

// File: tb/blkxfer_seq_tb_top.sv
`timescale 1ns/1ps
module blkxfer_seq_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_wr = 1'b0, count_wr = 1'b0;
  logic [7:0]       mode_wdata = '0;
  logic [CNT_W-1:0] count_wdata = '0;
  logic             block_done = 1'b0, abort = 1'b0, stop_ack = 1'b0;
  logic             stop_req, dma_start, busy, done, dir;
  logic [7:0]       mode_rd;
  logic [CNT_W-1:0] blocks_left;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  blkxfer_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .count_wr(count_wr), .count_wdata(count_wdata), .block_done(block_done),
    .abort(abort), .stop_req(stop_req), .stop_ack(stop_ack),
    .dma_start(dma_start), .busy(busy), .done(done), .dir(dir),
    .mode_rd(mode_rd), .blocks_left(blocks_left)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_count(input logic [CNT_W-1:0] v);
    count_wr = 1'b1; count_wdata = v; tick(); count_wr = 1'b0;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_wr = 1'b1; mode_wdata = v; tick(); mode_wr = 1'b0;
  endtask

  task automatic blk();
    block_done = 1'b1; tick(); block_done = 1'b0;
  endtask

  task automatic do_abort();
    abort = 1'b1; tick(); abort = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2", "busy after reset", busy, 0);
    chk("R5", "stop_req after reset", stop_req, 0);
    chk("R6", "done after reset", done, 0);
    chk("R1", "mode_rd after reset", mode_rd, 0);
    chk("R4", "blocks_left after reset", blocks_left, 0);
  endtask

  task automatic t_reserved();
    wr_mode(8'hBF);
    chk("R1", "reserved bits read zero", mode_rd, 8'h37);
    chk("R1", "dir read", dir, 1);
    chk("R2", "no start without data present", busy, 0);
  endtask

  task automatic t_multi_autostop();
    wr_count(3);
    wr_mode(8'h77);
    chk("R2", "busy at start", busy, 1);
    chk("R2", "count loaded", blocks_left, 3);
    chk("R3", "dma pulse", dma_start, 1);
    tick();
    chk("R3", "dma pulse one cycle", dma_start, 0);
    blk(); chk("R4", "after block 1", blocks_left, 2);
    blk(); chk("R4", "after block 2", blocks_left, 1);
    chk("R5", "no stop before last", stop_req, 0);
    blk(); chk("R4", "after block 3", blocks_left, 0);
    chk("R5", "stop after last", stop_req, 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5", "stop held", stop_req, 1);
      chk("R6", "no done before ack", done, 0);
    end
    stop_ack = 1'b1; tick(); stop_ack = 1'b0;
    chk("R6", "done after ack", done, 1);
    chk("R6", "idle after ack", busy, 0);
    chk("R5", "stop dropped", stop_req, 0);
    tick();
    chk("R6", "done one cycle", done, 0);
  endtask

  task automatic t_single();
    wr_count(5);
    wr_mode(8'h44);
    chk("R2", "single loads one", blocks_left, 1);
    chk("R3", "no dma when disabled", dma_start, 0);
    chk("R1", "dir write", dir, 0);
    blk();
    chk("R7", "single done", done, 1);
    chk("R7", "single idle", busy, 0);
    chk("R7", "single no stop", stop_req, 0);
    tick();
    chk("R7", "still no stop", stop_req, 0);
  endtask

  task automatic t_unbounded();
    wr_count(4);
    wr_mode(8'h64);
    for (int i = 0; i < 6; i++) begin
      blk();
      chk("R8", "counter frozen", blocks_left, 4);
      chk("R8", "still busy", busy, 1);
      chk("R8", "no stop", stop_req, 0);
    end
    do_abort();
    chk("R10", "abort idle", busy, 0);
    chk("R10", "abort no done", done, 0);
  endtask

  task automatic t_no_autostop();
    wr_count(2);
    wr_mode(8'h62);
    blk(); blk();
    chk("R9", "count reached zero", blocks_left, 0);
    chk("R9", "busy after last", busy, 1);
    chk("R9", "no stop", stop_req, 0);
    blk();
    chk("R9", "extra block ignored", blocks_left, 0);
    chk("R9", "still busy", busy, 1);
    chk("R9", "no done", done, 0);
    do_abort();
    chk("R10", "abort idle", busy, 0);
  endtask

  task automatic t_zero();
    wr_count(0);
    wr_mode(8'h63);
    chk("R11", "zero done", done, 1);
    chk("R11", "zero not busy", busy, 0);
    chk("R11", "zero no dma", dma_start, 0);
    chk("R11", "zero no stop", stop_req, 0);
    tick();
    chk("R11", "zero done one cycle", done, 0);
  endtask

  task automatic t_abort_stop();
    wr_count(1);
    wr_mode(8'h66);
    blk();
    chk("R5", "stop pending", stop_req, 1);
    do_abort();
    chk("R10", "stop dropped", stop_req, 0);
    chk("R10", "idle", busy, 0);
    chk("R10", "no done", done, 0);
  endtask

  task automatic t_busy_writes();
    wr_count(2);
    wr_mode(8'h66);
    wr_count(9);
    wr_mode(8'h01);
    chk("R12", "mode kept while busy", mode_rd, 8'h66);
    blk(); blk();
    stop_ack = 1'b1; tick(); stop_ack = 1'b0;
    chk("R6", "done", done, 1);
    wr_mode(8'h62);
    chk("R12", "count write while busy dropped", blocks_left, 2);
    do_abort();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_reserved();
    t_multi_autostop();
    t_single();
    t_unbounded();
    t_no_autostop();
    t_zero();
    t_abort_stop();
    t_busy_writes();
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule